// File: doc/BRIEF.md
# Pin Multiplexer Bank with Pad Control

This block sits between a set of on-chip peripherals and a bank of IO pads. Each pad carries a two-bit selector. Value 0 hands the pad to plain software-controlled GPIO. Values 1 to 3 hand it to one of three alternate peripheral functions. Whoever owns a pad drives its output value, its output enable and its pull-up. Because of this, a bidirectional peripheral can turn a line around on its own, with no register writes. A per-pad bit switches the pad between push-pull and open-drain drive. A pull-up request always wins over a pull-down request.

The input direction works the other way round. Each peripheral input function has its own route register, which names exactly one source pad. Two pads therefore cannot contend for one input. A function sees the pad's value only when the route is enabled and the chosen pad is in the mode that belongs to that function. In every other case the function sees a fixed idle level.

The pad-to-function path is purely combinational. Functions built as debounce-capable can instead be switched onto a filtered copy of their input. A shared prescaler sets the sample rate of that filter. A small synchronous register port configures the whole bank.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every pad configuration register reads 0. Every pad is then GPIO-owned with pad_oe, pad_out, pad_pu and pad_pd low. Every route is disabled, so each fn_in sits at its idle level (default 1,1,0,0 for functions 0..3). The prescaler reads 0.
- R2: Pad register p sits at address p (addr[5]=0). Its fields are sel=bits[1:0], od=bit2, out=bit3, oe=bit4, pu=bit5 and pd=bit6. With sel=0 and od=0, pad_out, pad_oe and pad_pu follow the out, oe and pu fields.
- R3: With sel=k (1..3), the logical output, enable and pull-up of pad p come from alt_out, alt_oe and alt_pu at bit index p*3+k-1. The pull-down still comes from the pd field.
- R4: With od=1, pad_out is 0. pad_oe is high only when the logical enable is high and the logical output is 0.
- R5: pad_pu and pad_pd are never both high. When both are requested, pad_pd is 0.
- R6: Route register f sits at address 32+f. Its fields are pad index=bits[2:0], debounce=bit14 and enable=bit15. When the route is enabled and the chosen pad's sel equals the function's mode (default modes 1,1,2,3 for functions 0..3), fn_in[f] equals that pad's pad_in in the same cycle.
- R7: When the route is disabled, or the chosen pad's sel differs from the function's mode, the routed value is the function's idle level.
- R8: For a debounce-capable function (default: functions 2 and 3) with the debounce bit set, fn_in changes only after 3 consecutive sample ticks that each see the new routed value. A tick occurs every (prescaler+1) clocks, and the prescaler is at address 48, bits[7:0]. On functions that are not capable, the debounce bit has no effect.
- R9: Every configuration register reads back what was written to its fields. Address 49 reads the raw pad_in vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| alt_out | input | NUM_PADS*3 | Peripheral output values, index pad*3+alt-1 |
| alt_oe | input | NUM_PADS*3 | Peripheral output enables |
| alt_pu | input | NUM_PADS*3 | Peripheral pull-up requests |
| pad_in | input | NUM_PADS | Values seen at the pads |
| pad_out | output | NUM_PADS | Pad output data |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_pu | output | NUM_PADS | Pad pull-up enable |
| pad_pd | output | NUM_PADS | Pad pull-down enable |
| fn_in | output | NUM_IN | Inputs delivered to peripheral functions |

## Verification
Most faults in this block show up at once. A corrupt pad selector or open-drain bit shows up on pad_out or pad_oe in the same cycle, and a corrupt route register shows up on fn_in in the cycle after the write. Debounce state is slower to expose. A wrong counter or prescaler value only becomes visible as an fn_in edge that comes one or more sample ticks early or late, so the bench holds pad values for runs of varying length and compares fn_in against an independent model on every clock.

// File: rtl/pinmux_pkg.sv
// Shared constants and types for the pin multiplexer bank.
// Assumes a 6-bit register address and 16-bit register data.
package pinmux_pkg;
    localparam int ADDR_W      = 6;
    localparam int DATA_W      = 16;
    localparam int NUM_ALT     = 3;
    localparam int SEL_W       = 2;
    localparam int ROUTE_EN_B  = 15;
    localparam int ROUTE_DB_B  = 14;
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 6'h30;
    localparam logic [ADDR_W-1:0] ADDR_PADIN = 6'h31;

    // Pad configuration word, LSB first: sel[1:0], od, out, oe, pu, pd
    typedef struct packed {
        logic             pd;
        logic             pu;
        logic             oe;
        logic             out;
        logic             od;
        logic [SEL_W-1:0] sel;
    } pad_cfg_t;

    localparam int CFG_W = $bits(pad_cfg_t);
endpackage

// File: rtl/pinmux_regs.sv
// Configuration registers for the bank: one word per pad, one route word per
// input function, and the debounce prescaler. Reads are combinational.
// Assumes NUM_PADS <= 16 and NUM_IN <= 16 so the address map fits.
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_PADS = 8,
    parameter int NUM_IN   = 4,
    parameter int PAD_W    = 3,
    parameter int PRESC_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output pad_cfg_t            cfg [NUM_PADS],
    output logic [PAD_W-1:0]    route_pad [NUM_IN],
    output logic [NUM_IN-1:0]   route_en,
    output logic [NUM_IN-1:0]   route_db,
    output logic [PRESC_W-1:0]  presc
);
    logic pad_hit;
    logic route_hit;
    logic unused_wdata;

    assign pad_hit      = (reg_addr[5] == 1'b0);
    assign route_hit    = (reg_addr[5:4] == 2'b10);
    assign unused_wdata = ^reg_wdata;

    genvar p;
    generate
        for (p = 0; p < NUM_PADS; p++) begin : g_pad
            // Hold the configuration word of one pad
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg[p] <= '0;
                else if (reg_we && pad_hit && reg_addr[4:0] == 5'(p))
                    cfg[p] <= pad_cfg_t'(reg_wdata[CFG_W-1:0]);
            end
        end
    endgenerate

    genvar f;
    generate
        for (f = 0; f < NUM_IN; f++) begin : g_route
            // Hold the route word of one input function
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    route_pad[f] <= '0;
                    route_en[f]  <= 1'b0;
                    route_db[f]  <= 1'b0;
                end else if (reg_we && route_hit && reg_addr[3:0] == 4'(f)) begin
                    route_pad[f] <= reg_wdata[PAD_W-1:0];
                    route_en[f]  <= reg_wdata[ROUTE_EN_B];
                    route_db[f]  <= reg_wdata[ROUTE_DB_B];
                end
            end
        end
    endgenerate

    // Hold the debounce sample prescaler
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc <= '0;
        else if (reg_we && reg_addr == ADDR_PRESC)
            presc <= reg_wdata[PRESC_W-1:0];
    end

    // Select the read data for the current address
    always_comb begin
        reg_rdata = '0;
        if (pad_hit) begin
            for (int i = 0; i < NUM_PADS; i++)
                if (reg_addr[4:0] == 5'(i))
                    reg_rdata[CFG_W-1:0] = cfg[i];
        end else if (route_hit) begin
            for (int i = 0; i < NUM_IN; i++)
                if (reg_addr[3:0] == 4'(i)) begin
                    reg_rdata[PAD_W-1:0]  = route_pad[i];
                    reg_rdata[ROUTE_EN_B] = route_en[i];
                    reg_rdata[ROUTE_DB_B] = route_db[i];
                end
        end else if (reg_addr == ADDR_PRESC) begin
            reg_rdata[PRESC_W-1:0] = presc;
        end else if (reg_addr == ADDR_PADIN) begin
            reg_rdata[NUM_PADS-1:0] = pad_in;
        end
    end
endmodule

// File: rtl/pinmux_pad_drive.sv
// Output stage of one pad. Picks the owner (GPIO word or one of the
// alternate peripherals), then applies open-drain and pull exclusion.
// Assumes the alternate inputs are indexed by selector value minus one.
module pinmux_pad_drive
    import pinmux_pkg::*;
(
    input  pad_cfg_t           cfg,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic [NUM_ALT-1:0] alt_oe,
    input  logic [NUM_ALT-1:0] alt_pu,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               pad_pu,
    output logic               pad_pd
);
    logic lvl;
    logic en;
    logic up;

    // Choose the owner of the pad
    always_comb begin
        if (cfg.sel == '0) begin
            lvl = cfg.out;
            en  = cfg.oe;
            up  = cfg.pu;
        end else begin
            lvl = alt_out[cfg.sel - SEL_W'(1)];
            en  = alt_oe[cfg.sel - SEL_W'(1)];
            up  = alt_pu[cfg.sel - SEL_W'(1)];
        end
    end

    // Apply drive style and pull exclusion
    always_comb begin
        pad_pu = up;
        pad_pd = cfg.pd & ~up;
        if (cfg.od) begin
            pad_out = 1'b0;
            pad_oe  = en & ~lvl;
        end else begin
            pad_out = lvl;
            pad_oe  = en;
        end
    end
endmodule

// File: rtl/pinmux_in_route.sv
// Input selector for one peripheral function: passes the one routed pad
// when it is enabled and the pad is in this function's mode, else the idle level.
// Assumes NUM_PADS is a power of two so every index names a real pad.
module pinmux_in_route #(
    parameter int         NUM_PADS = 8,
    parameter int         PAD_W    = 3,
    parameter logic [1:0] MODE     = 2'd1,
    parameter logic       IDLE     = 1'b0
) (
    input  logic [NUM_PADS-1:0]   pad_in,
    input  logic [2*NUM_PADS-1:0] sel_flat,
    input  logic [PAD_W-1:0]      route_pad,
    input  logic                  route_en,
    output logic                  raw
);
    // Gate the routed pad on enable and mode match
    always_comb begin
        raw = IDLE;
        if (route_en && sel_flat[{route_pad, 1'b0} +: 2] == MODE)
            raw = pad_in[route_pad];
    end
endmodule

// File: rtl/pinmux_debounce.sv
// Debounce filter for one input: on each sample tick it counts ticks that
// disagree with the filtered value and adopts the new value after DEB_N in a row.
// Assumes DEB_N >= 2.
module pinmux_debounce #(
    parameter int   DEB_N = 3,
    parameter logic IDLE  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    localparam int CNT_W = $clog2(DEB_N);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_N - 1);

    logic [CNT_W-1:0] run;

    // Track the run of disagreeing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= IDLE;
            run   <= '0;
        end else if (tick) begin
            if (raw == clean) begin
                run <= '0;
            end else if (run == CNT_LAST) begin
                clean <= raw;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pinmux_bank.sv
// Pin multiplexer bank. Each pad is owned by GPIO or one of three alternate
// peripherals. Each input function reads exactly one routed pad, optionally
// through a debounce filter sampled at a programmable rate.
// Assumes NUM_PADS is a power of two between 2 and 16, and NUM_IN <= 16.
module pinmux_bank
    import pinmux_pkg::*;
#(
    parameter int                NUM_PADS = 8,
    parameter int                NUM_IN   = 4,
    parameter int                PRESC_W  = 8,
    parameter int                DEB_N    = 3,
    parameter logic [2*NUM_IN-1:0] IN_MODE = 8'b11_10_01_01,
    parameter logic [NUM_IN-1:0] IDLE_LVL = 4'b0011,
    parameter logic [NUM_IN-1:0] DEB_CAP  = 4'b1100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [5:0]                  reg_addr,
    input  logic [15:0]                 reg_wdata,
    output logic [15:0]                 reg_rdata,
    input  logic [NUM_PADS*NUM_ALT-1:0] alt_out,
    input  logic [NUM_PADS*NUM_ALT-1:0] alt_oe,
    input  logic [NUM_PADS*NUM_ALT-1:0] alt_pu,
    input  logic [NUM_PADS-1:0]         pad_in,
    output logic [NUM_PADS-1:0]         pad_out,
    output logic [NUM_PADS-1:0]         pad_oe,
    output logic [NUM_PADS-1:0]         pad_pu,
    output logic [NUM_PADS-1:0]         pad_pd,
    output logic [NUM_IN-1:0]           fn_in
);
    localparam int PAD_W = $clog2(NUM_PADS);

    pad_cfg_t                cfg [NUM_PADS];
    logic [PAD_W-1:0]        route_pad [NUM_IN];
    logic [NUM_IN-1:0]       route_en;
    logic [NUM_IN-1:0]       route_db;
    logic [PRESC_W-1:0]      presc;
    logic [PRESC_W-1:0]      presc_cnt;
    logic                    tick;
    logic [2*NUM_PADS-1:0]   sel_flat;
    logic [NUM_PADS-1:0]     od_flat;
    logic [NUM_PADS-1:0]     goe_flat;
    logic [NUM_IN-1:0]       raw;
    logic [NUM_IN-1:0]       deb;
    logic [NUM_IN-1:0]       db_use;
    logic                    unused_db;

    assign unused_db = ^route_db;

    pinmux_regs #(
        .NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN), .PAD_W(PAD_W), .PRESC_W(PRESC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .cfg(cfg), .route_pad(route_pad), .route_en(route_en),
        .route_db(route_db), .presc(presc)
    );

    // Sample tick: one pulse every presc+1 clocks
    assign tick = (presc_cnt >= presc);

    // Count clocks between debounce samples
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_cnt <= '0;
        else if (tick)
            presc_cnt <= '0;
        else
            presc_cnt <= presc_cnt + 1'b1;
    end

    genvar p;
    generate
        for (p = 0; p < NUM_PADS; p++) begin : g_pad
            assign sel_flat[2*p +: 2] = cfg[p].sel;
            assign od_flat[p]         = cfg[p].od;
            assign goe_flat[p]        = cfg[p].oe;

            pinmux_pad_drive u_drive (
                .cfg(cfg[p]),
                .alt_out(alt_out[p*NUM_ALT +: NUM_ALT]),
                .alt_oe(alt_oe[p*NUM_ALT +: NUM_ALT]),
                .alt_pu(alt_pu[p*NUM_ALT +: NUM_ALT]),
                .pad_out(pad_out[p]), .pad_oe(pad_oe[p]),
                .pad_pu(pad_pu[p]), .pad_pd(pad_pd[p])
            );
        end
    endgenerate

    genvar f;
    generate
        for (f = 0; f < NUM_IN; f++) begin : g_fn
            pinmux_in_route #(
                .NUM_PADS(NUM_PADS), .PAD_W(PAD_W),
                .MODE(IN_MODE[2*f +: 2]), .IDLE(IDLE_LVL[f])
            ) u_route (
                .pad_in(pad_in), .sel_flat(sel_flat), .route_pad(route_pad[f]),
                .route_en(route_en[f]), .raw(raw[f])
            );

            if (DEB_CAP[f]) begin : g_db
                pinmux_debounce #(.DEB_N(DEB_N), .IDLE(IDLE_LVL[f])) u_db (
                    .clk(clk), .rst_n(rst_n), .tick(tick),
                    .raw(raw[f]), .clean(deb[f])
                );
                assign db_use[f] = route_db[f];
            end else begin : g_nodb
                assign deb[f]    = raw[f];
                assign db_use[f] = 1'b0;
            end

            assign fn_in[f] = db_use[f] ? deb[f] : raw[f];
        end
    endgenerate
endmodule

// File: rtl/pinmux_checker.sv
// Assertion checker for the pin multiplexer bank, attached through bind.
// Observes pad outputs, function inputs and a few configuration nets.
module pinmux_checker #(
    parameter int                NUM_PADS = 8,
    parameter int                NUM_IN   = 4,
    parameter logic [NUM_IN-1:0] IDLE_LVL = 4'b0011,
    parameter logic [NUM_IN-1:0] DEB_CAP  = 4'b1100
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PADS-1:0]   pad_out,
    input logic [NUM_PADS-1:0]   pad_oe,
    input logic [NUM_PADS-1:0]   pad_pu,
    input logic [NUM_PADS-1:0]   pad_pd,
    input logic [NUM_IN-1:0]     fn_in,
    input logic [2*NUM_PADS-1:0] sel_flat,
    input logic [NUM_PADS-1:0]   od_flat,
    input logic [NUM_PADS-1:0]   goe_flat,
    input logic [NUM_IN-1:0]     route_en,
    input logic [NUM_IN-1:0]     db_use,
    input logic                  tick
);
    genvar p;
    generate
        for (p = 0; p < NUM_PADS; p++) begin : g_pad
            AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_pu[p] && pad_pd[p])); // R5
            AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                od_flat[p] |-> !pad_out[p]); // R4
            AST_GPIO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_flat[2*p +: 2] == 2'd0 && !goe_flat[p]) |-> !pad_oe[p]); // R2
        end
    endgenerate

    genvar f;
    generate
        for (f = 0; f < NUM_IN; f++) begin : g_fn
            AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                (!route_en[f] && !db_use[f]) |-> (fn_in[f] == IDLE_LVL[f])); // R7
            if (DEB_CAP[f]) begin : g_db
                AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (db_use[f] && !tick) |=> (!db_use[f] || $stable(fn_in[f]))); // R8
            end
        end
    endgenerate
endmodule

bind pinmux_bank pinmux_checker #(
    .NUM_PADS(NUM_PADS), .NUM_IN(NUM_IN), .IDLE_LVL(IDLE_LVL), .DEB_CAP(DEB_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .fn_in(fn_in), .sel_flat(sel_flat),
    .od_flat(od_flat), .goe_flat(goe_flat), .route_en(route_en),
    .db_use(db_use), .tick(tick)
);

// File: tb/sim_pinmux_bank.sv
// Bench for pinmux_bank: a behavioural model of the register state, pad
// drive and debounce is updated on each rising edge and compared on each
// falling edge.
module sim_pinmux_bank;
    localparam int NP = 8;
    localparam int NI = 4;
    localparam int DEBN = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [NP*3-1:0] alt_out, alt_oe, alt_pu;
    logic [NP-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
    logic [NI-1:0] fn_in;

    always #5 clk = ~clk;

    pinmux_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_out(alt_out),
        .alt_oe(alt_oe), .alt_pu(alt_pu), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .fn_in(fn_in)
    );

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 0;

    // Model state
    int m_cfg [NP];
    int m_rpad [NI];
    bit m_ren [NI];
    bit m_rdb [NI];
    int m_presc;
    int m_pc;
    bit m_stab [NI];
    int m_cnt [NI];
    int MODE [NI] = '{1, 1, 2, 3};
    bit IDLE [NI] = '{1, 1, 0, 0};
    bit CAP  [NI] = '{0, 0, 1, 1};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_raw(int f);
        int p;
        if (!m_ren[f]) return IDLE[f];
        p = m_rpad[f];
        if ((m_cfg[p] & 3) != MODE[f]) return IDLE[f];
        return pad_in[p];
    endfunction

    function automatic bit exp_fn(int f);
        if (CAP[f] && m_rdb[f]) return m_stab[f];
        return exp_raw(f);
    endfunction

    // Expected {out, oe, pu, pd} of one pad
    function automatic logic [3:0] exp_pad(int p);
        int sel, k;
        bit od, l, e, u, d;
        sel = m_cfg[p] & 3;
        od  = m_cfg[p][2];
        if (sel == 0) begin
            l = m_cfg[p][3]; e = m_cfg[p][4]; u = m_cfg[p][5];
        end else begin
            k = p * 3 + sel - 1;
            l = alt_out[k]; e = alt_oe[k]; u = alt_pu[k];
        end
        d = m_cfg[p][6] && !u;
        if (od) return {1'b0, e && !l, u, d};
        return {l, e, u, d};
    endfunction

    // Advance the model on each rising edge
    always @(posedge clk) begin
        bit t;
        bit r;
        int a;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) m_cfg[p] = 0;
            for (int f = 0; f < NI; f++) begin
                m_rpad[f] = 0; m_ren[f] = 0; m_rdb[f] = 0;
                m_stab[f] = IDLE[f]; m_cnt[f] = 0;
            end
            m_presc = 0;
            m_pc = 0;
        end else begin
            t = (m_pc >= m_presc);
            for (int f = 0; f < NI; f++) begin
                r = exp_raw(f);
                if (CAP[f] && t) begin
                    if (r == m_stab[f]) m_cnt[f] = 0;
                    else if (m_cnt[f] == DEBN - 1) begin m_stab[f] = r; m_cnt[f] = 0; end
                    else m_cnt[f]++;
                end
            end
            m_pc = t ? 0 : m_pc + 1;
            if (reg_we) begin
                a = reg_addr;
                if (a < NP) m_cfg[a] = reg_wdata & 16'h7f;
                else if (a >= 32 && a < 32 + NI) begin
                    m_rpad[a-32] = reg_wdata & 7;
                    m_ren[a-32]  = reg_wdata[15];
                    m_rdb[a-32]  = reg_wdata[14];
                end else if (a == 48) m_presc = reg_wdata & 16'hff;
            end
        end
    end

    // Compare every output on each falling edge
    always @(negedge clk) begin
        int sel;
        logic [3:0] e;
        string tag;
        if (chk_on) begin
            for (int p = 0; p < NP; p++) begin
                sel = m_cfg[p] & 3;
                e = exp_pad(p);
                tag = m_cfg[p][2] ? "R4 open-drain" : (sel == 0 ? "R2 gpio" : "R3 alt");
                check(tag, {pad_out[p], pad_oe[p]}, e[3:2]);
                check("R5 pulls", {pad_pu[p], pad_pd[p]}, e[1:0]);
            end
            for (int f = 0; f < NI; f++) begin
                if (CAP[f] && m_rdb[f]) tag = "R8 debounce";
                else if (m_ren[f] && (m_cfg[m_rpad[f]] & 3) == MODE[f]) tag = "R6 route";
                else tag = "R7 idle";
                check(tag, fn_in[f], exp_fn(f));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 16'(d);
        @(negedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk); #1;
        reg_addr = 6'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wiggle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            alt_out = 24'($urandom); alt_oe = 24'($urandom); alt_pu = 24'($urandom);
            pad_in = 8'($urandom);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        alt_out = '0; alt_oe = '0; alt_pu = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state
        rd(0, 0, "R1 pad cfg");
        rd(33, 0, "R1 route");
        rd(48, 0, "R1 prescaler");
        check("R1 oe", pad_oe, 0);
        check("R1 fn idle", fn_in, 4'b0011);

        // R2, R4, R5: GPIO ownership
        wr(0, 16'h18);
        wr(1, 16'h60);
        wr(2, 16'h1c);
        wr(3, 16'h14);
        wr(7, 16'h08);
        @(negedge clk); #2;
        check("R2 pad0 out/oe", {pad_out[0], pad_oe[0]}, 2'b11);
        check("R2 pad7 oe off", {pad_out[7], pad_oe[7]}, 2'b10);
        check("R5 pad1 pu wins", {pad_pu[1], pad_pd[1]}, 2'b10);
        check("R4 pad2 released", {pad_out[2], pad_oe[2]}, 2'b00);
        check("R4 pad3 pulls low", {pad_out[3], pad_oe[3]}, 2'b01);

        // R3: alternate ownership, with pd and open-drain
        wr(4, 16'h41);
        wr(5, 16'h06);
        wr(6, 16'h03);
        wiggle(200);

        // R6, R7, R8 routes and debounce
        wr(32, 16'h8004);
        wr(33, 16'h8005);
        wr(34, 16'h8005);
        wr(35, 16'hC006);
        wr(48, 2);
        wiggle(200);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            pad_in = 8'($urandom);
            repeat ($urandom_range(1, 12)) @(negedge clk);
        end

        // R8: explicit debounce timing on function 3 (pad 6)
        @(negedge clk); #1 pad_in[6] = 1'b0;
        repeat (30) @(negedge clk);
        #1 check("R8 settled low", fn_in[3], 1'b0);
        pad_in[6] = 1'b1;
        repeat (2) @(negedge clk);
        #1 check("R8 held early", fn_in[3], 1'b0);
        repeat (12) @(negedge clk);
        #1 check("R8 adopted", fn_in[3], 1'b1);

        // R8: debounce bit ignored on non-capable function 1 routed to pad 4
        wr(33, 16'hC004);
        wiggle(50);
        // R7: pad 4 leaves function 0's mode
        wr(4, 16'h02);
        wiggle(50);
        // R6/R8: debounce on function 2 with slower prescaler
        wr(34, 16'hC005);
        wr(48, 5);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); #1;
            pad_in = 8'($urandom);
            repeat ($urandom_range(1, 25)) @(negedge clk);
        end

        // R9: read-back
        rd(5, 16'h06, "R9 pad cfg");
        rd(4, 16'h02, "R9 pad cfg");
        rd(34, 16'hC005, "R9 route");
        rd(35, 16'hC006, "R9 route");
        rd(48, 5, "R9 prescaler");
        @(negedge clk); #1 pad_in = 8'hA5;
        rd(49, 16'h00A5, "R9 pad inputs");

        finish_run();
    end
endmodule